// File: doc/BRIEF.md
# DRAM Geometry Probe Aliasing Model

This block models what a memory-sizing routine sees when it writes and reads probe addresses after programming a DRAM geometry (row, bank and column address bit counts) that may not match the real part. A configuration write sets the programmed geometry. Each probe address is then cut into column, bank and row fields of the programmed widths. Each field is reduced to a small index, and the three indices select one word of a small cell store. Because many addresses reduce to the same indices, a probe write becomes visible at other addresses in a sparse, predictable pattern, and that is the aliasing a sizing routine uses to find the real size.

The real geometry comes from a fixed table keyed by a RAM size strap. The aliasing window opens only when the programmed geometry differs from the real one. While the window is closed, probe reads return zero and probe writes are dropped. The `windowEn` output tells the surrounding environment that accesses should go to plain memory instead. The probe port is a single 32-bit word port: a write lands in the cycle of the request, and read data comes back one cycle later.

Top module: `geoProbeAlias`

## Requirements
- R1: After reset `windowEn` and `rdValid` are 0 and every cell holds 0, so the first read through an open window returns 0.
- R2: A configuration write with bit 0 clear, under a supported size, sets row bits = cfg[7:4]+1, bank bits = cfg[2]+2 and column bits = cfg[11:8]+3, and sets `windowEn` to 1 exactly when any of the three counts differs from the real geometry. Without a configuration write, `windowEn` keeps its value.
- R3: A configuration write with bit 0 set (dual rank) has no effect: the geometry and `windowEn` keep their values.
- R4: The real geometry, given as (row, bank, column) bits, is (12,3,13) for `ramSizeMib`=256, (13,3,13) for 512 and (14,3,13) for 1024. Under any other size, configuration writes are ignored and probe reads return 0.
- R5: In a probe address the column field occupies the lowest programmed-column bits, the bank field sits directly above it, and the row field sits directly above the bank field.
- R6: Each field becomes the index of its highest set bit, counting only bit positions below the real bit count for that field. A field with no such bit gives index 0, so addresses with equal indices alias to one cell.
- R7: A probe write through an open window stores `reqWdata` in the addressed cell at the request's clock edge. A probe read returns `rdValid`=1 with the cell contents on the following cycle.
- R8: While the window is closed, a read still returns `rdValid`=1 with `rdData`=0, and a write changes no cell.
- R9: Only `reqBytes`=4 is accepted. Any other size writes no cell and gives no `rdValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ramSizeMib | input | 12 | Real RAM size strap in MiB |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWdata | input | 12 | Configuration word: bit 0 dual rank, bit 2 bank, bits 7:4 row, bits 11:8 column |
| reqValid | input | 1 | Probe request valid |
| reqWrite | input | 1 | Probe request is a write |
| reqAddr | input | 32 | Probe byte offset |
| reqBytes | input | 3 | Access size in bytes |
| reqWdata | input | 32 | Probe write data |
| rdValid | output | 1 | Read data valid, one cycle after a read |
| rdData | output | 32 | Read data |
| windowEn | output | 1 | Aliasing window open; low means plain memory |

## Verification
The bench goes after the alias corners. Column values 0x400 and 0x7FF must share a cell. A row field whose only set bit lies above the real row count must fall onto index 0. Bank values 0 and 1 must collapse together. A design that picked the lowest set bit, or counted bits above the real width, would return stale or zero data at the alias address. Configuration writes with bit 0 set, writes that match the real geometry, and writes under an unsupported size are each checked for a window that must not move. A design that decoded them anyway would open or close the window too early. Narrow accesses and closed-window writes are checked by reading the target cell back afterwards, so a leaking write shows up as changed data.

// File: rtl/geoPkg.sv
package geoPkg;

  typedef struct packed {
    logic [4:0] rowBits;
    logic [2:0] bankBits;
    logic [4:0] colBits;
  } geo_t;

  typedef struct packed {
    logic ok;
    geo_t geo;
  } realGeo_t;

  typedef struct packed {
    logic cellWr;
    logic cellRd;
    logic blankRd;
  } strobe_t;

  function automatic realGeo_t lookupReal(logic [11:0] mib);
    realGeo_t res;
    res = '0;
    case (mib)
      12'd256:  res = '{ok: 1'b1, geo: '{rowBits: 5'd12, bankBits: 3'd3, colBits: 5'd13}};
      12'd512:  res = '{ok: 1'b1, geo: '{rowBits: 5'd13, bankBits: 3'd3, colBits: 5'd13}};
      12'd1024: res = '{ok: 1'b1, geo: '{rowBits: 5'd14, bankBits: 3'd3, colBits: 5'd13}};
      default:  res = '0;
    endcase
    return res;
  endfunction

  function automatic logic [31:0] lowMask(logic [4:0] n);
    return (32'h1 << n) - 32'h1;
  endfunction

  function automatic logic [4:0] topBitBelow(logic [31:0] v, logic [4:0] lim);
    logic [4:0] res;
    res = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < int'(lim) && v[i]) res = 5'(i);
    end
    return res;
  endfunction

endpackage

// File: rtl/geoCtrl.sv
module geoCtrl
  import geoPkg::*;
#(
  parameter int CFG_W      = 12,
  parameter int WORD_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [11:0]      ramSizeMib,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [2:0]       reqBytes,
  output geo_t             progGeo,
  output geo_t             realGeo,
  output logic             windowEn,
  output strobe_t          strb
);

  realGeo_t realSel;
  geo_t     decoded;
  logic     cfgTake;
  logic     accessOk;
  logic     live;

  always_comb begin
    realSel  = lookupReal(ramSizeMib);
    realGeo  = realSel.geo;
    decoded.rowBits  = {1'b0, cfgWdata[7:4]} + 5'd1;
    decoded.bankBits = {2'b0, cfgWdata[2]} + 3'd2;
    decoded.colBits  = {1'b0, cfgWdata[11:8]} + 5'd3;
    cfgTake  = cfgWrEn && !cfgWdata[0] && realSel.ok;
    accessOk = reqValid && (reqBytes == 3'(WORD_BYTES));
    live     = windowEn && realSel.ok;
    strb.cellWr  = accessOk && reqWrite && live;
    strb.cellRd  = accessOk && !reqWrite && live;
    strb.blankRd = accessOk && !reqWrite && !live;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progGeo  <= '0;
      windowEn <= 1'b0;
    end else if (cfgTake) begin
      progGeo  <= decoded;
      windowEn <= (decoded != realSel.geo);
    end
  end

  a_r3_dual_rank_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgWdata[0]) |=> ($stable(progGeo) && $stable(windowEn)));

  a_r2_window_holds: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(windowEn));

  a_r4_unsupported_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !lookupReal(ramSizeMib).ok) |=> ($stable(progGeo) && $stable(windowEn)));

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.cellWr, strb.cellRd, strb.blankRd}));

endmodule

// File: rtl/geoDatapath.sv
module geoDatapath
  import geoPkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int ROW_IDX_N  = 16,
  parameter int BANK_IDX_N = 3,
  parameter int COL_IDX_N  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  geo_t              progGeo,
  input  geo_t              realGeo,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  localparam int ROW_IW = $clog2(ROW_IDX_N);
  localparam int BANK_IW = $clog2(BANK_IDX_N);
  localparam int COL_IW = $clog2(COL_IDX_N);
  localparam int CELL_N = ROW_IDX_N * BANK_IDX_N * COL_IDX_N;
  localparam int CELL_W = $clog2(CELL_N);

  logic [31:0]        addr32;
  logic [31:0]        colField;
  logic [31:0]        bankField;
  logic [31:0]        rowField;
  logic [4:0]         rowShift;
  logic [ROW_IW-1:0]  rowIdx;
  logic [BANK_IW-1:0] bankIdx;
  logic [COL_IW-1:0]  colIdx;
  logic [CELL_W-1:0]  cellIdx;
  logic [DATA_W-1:0]  cellView [CELL_N];

  always_comb begin
    addr32    = 32'(reqAddr);
    rowShift  = progGeo.colBits + {2'b0, progGeo.bankBits};
    colField  = addr32 & lowMask(progGeo.colBits);
    bankField = (addr32 >> progGeo.colBits) & lowMask({2'b0, progGeo.bankBits});
    rowField  = (addr32 >> rowShift) & lowMask(progGeo.rowBits);
    rowIdx    = ROW_IW'(topBitBelow(rowField, realGeo.rowBits));
    bankIdx   = BANK_IW'(topBitBelow(bankField, {2'b0, realGeo.bankBits}));
    colIdx    = COL_IW'(topBitBelow(colField, realGeo.colBits));
    cellIdx   = CELL_W'((int'(rowIdx) * BANK_IDX_N + int'(bankIdx)) * COL_IDX_N + int'(colIdx));
  end

  for (genvar k = 0; k < CELL_N; k++) begin : gCell
    logic [DATA_W-1:0] word;
    logic              hit;
    assign hit = strb.cellWr && (cellIdx == CELL_W'(k));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    word <= '0;
      else if (hit) word <= reqWdata;
    end
    assign cellView[k] = word;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.cellRd || strb.blankRd;
      rdData  <= strb.cellRd ? cellView[cellIdx] : '0;
    end
  end

  a_r8_blank_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.blankRd |=> (rdValid && rdData == '0));

  a_r7_read_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    strb.cellRd |=> rdValid);

  a_r6_index_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cellRd || strb.cellWr) |->
      (5'(rowIdx) < realGeo.rowBits || rowIdx == '0) &&
      (5'(colIdx) < realGeo.colBits || colIdx == '0));

  a_r7_write_read_back: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cellRd && $past(strb.cellWr) && cellIdx == $past(cellIdx)) |=>
      (rdData == $past(reqWdata, 2)));

endmodule

// File: rtl/geoProbeAlias.sv
module geoProbeAlias
  import geoPkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int CFG_W      = 12,
  parameter int ROW_IDX_N  = 16,
  parameter int BANK_IDX_N = 3,
  parameter int COL_IDX_N  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       ramSizeMib,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWdata,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqBytes,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              windowEn
);

  localparam int WORD_BYTES = DATA_W / 8;

  geo_t    progGeo;
  geo_t    realGeo;
  strobe_t strb;

  geoCtrl #(.CFG_W(CFG_W), .WORD_BYTES(WORD_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .ramSizeMib(ramSizeMib),
    .cfgWrEn(cfgWrEn), .cfgWdata(cfgWdata),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqBytes(reqBytes),
    .progGeo(progGeo), .realGeo(realGeo), .windowEn(windowEn), .strb(strb)
  );

  geoDatapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ROW_IDX_N(ROW_IDX_N),
    .BANK_IDX_N(BANK_IDX_N), .COL_IDX_N(COL_IDX_N)
  ) uData (
    .clk(clk), .rstN(rstN), .progGeo(progGeo), .realGeo(realGeo), .strb(strb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdValid(rdValid), .rdData(rdData)
  );

  a_r9_narrow_no_response: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqBytes != 3'(WORD_BYTES)) |=> !rdValid);

  a_r7_idle_no_response: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rdValid);

endmodule

// File: tb/tb_geoProbeAlias.sv
module tb_geoProbeAlias;

  localparam int CLK_PERIOD = 10;
  localparam int CELLS = 16 * 3 * 13;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] ramSizeMib = 12'd256;
  logic        cfgWrEn = 1'b0;
  logic [11:0] cfgWdata = '0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [2:0]  reqBytes = 3'd4;
  logic [31:0] reqWdata = '0;
  logic        rdValid;
  logic [31:0] rdData;
  logic        windowEn;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int pr = 0, pb = 0, pc = 0;
  int rr = 12, rb = 3, rc = 13;
  bit sizeOk = 1;
  bit expWin = 0;
  int unsigned mem [CELLS];

  always #(CLK_PERIOD / 2) clk = ~clk;

  geoProbeAlias dut (
    .clk(clk), .rstN(rstN), .ramSizeMib(ramSizeMib), .cfgWrEn(cfgWrEn),
    .cfgWdata(cfgWdata), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBytes(reqBytes), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .windowEn(windowEn)
  );

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int hb(int unsigned v, int lim);
    int res = 0;
    for (int i = 0; i < lim; i++) if (v[i]) res = i;
    return res;
  endfunction

  function automatic int unsigned msk(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  function automatic int cellOf(int unsigned a);
    int unsigned cf = a & msk(pc);
    int unsigned bf = (a >> pc) & msk(pb);
    int unsigned rf = ((pc + pb) >= 32) ? 0 : ((a >> (pc + pb)) & msk(pr));
    return (hb(rf, rr) * 3 + hb(bf, rb)) * 13 + hb(cf, rc);
  endfunction

  task automatic setSize(int mib);
    @(negedge clk);
    ramSizeMib = 12'(mib);
    sizeOk = 1;
    case (mib)
      256: begin rr = 12; rb = 3; rc = 13; end
      512: begin rr = 13; rb = 3; rc = 13; end
      1024: begin rr = 14; rb = 3; rc = 13; end
      default: sizeOk = 0;
    endcase
  endtask

  task automatic cfg(logic [11:0] v, string tag);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWdata = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (!v[0] && sizeOk) begin
      pr = int'(v[7:4]) + 1;
      pb = int'(v[2]) + 2;
      pc = int'(v[11:8]) + 3;
      expWin = (pr != rr) || (pb != rb) || (pc != rc);
    end
    check(windowEn == expWin, tag, windowEn, expWin);
  endtask

  task automatic wr(int unsigned a, int unsigned d, int bytes);
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = 1'b1;
    reqAddr = a;
    reqWdata = d;
    reqBytes = 3'(bytes);
    @(negedge clk);
    reqValid = 1'b0;
    if (bytes == 4 && expWin && sizeOk) mem[cellOf(a)] = d;
  endtask

  task automatic rd(int unsigned a, int bytes, string tag);
    int unsigned exp;
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = 1'b0;
    reqAddr = a;
    reqBytes = 3'(bytes);
    exp = (expWin && sizeOk) ? mem[cellOf(a)] : 0;
    @(negedge clk);
    reqValid = 1'b0;
    if (bytes == 4) begin
      check(rdValid == 1'b1, {tag, " rdValid"}, rdValid, 1);
      check(rdData == exp, {tag, " rdData"}, rdData, exp);
    end else begin
      check(rdValid == 1'b0, {tag, " narrow rdValid"}, rdValid, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < CELLS; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    check(windowEn == 1'b0, "R1 reset window", windowEn, 0);
    check(rdValid == 1'b0, "R1 reset rdValid", rdValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: geometry equal to the real 256 MiB part keeps the window closed
    cfg(12'hAB4, "R2 matching geometry");
    rd(32'h0000_0040, 4, "R8 closed read");
    wr(32'h0000_0040, 32'hDEAD_BEEF, 4);
    // R3: dual-rank write must not open the window
    cfg(12'h8F5, "R3 dual rank ignored");
    // R2: mismatch row 16, bank 3, col 11
    cfg(12'h8F4, "R2 mismatch opens window");
    rd(32'h0000_0040, 4, "R1 cell zero after reset / R8 write dropped");

    // R5/R6 directed aliasing (col field a[10:0], bank a[13:11], row a[29:14])
    wr(32'h0000_0400, 32'h1111_2222, 4);
    rd(32'h0000_07FF, 4, "R6 column alias");
    check(rdData == 32'h1111_2222, "R6 column alias literal", rdData, 32'h1111_2222);
    wr(32'h2000_0000, 32'h3333_4444, 4);
    rd(32'h0000_0000, 4, "R6 row above real width maps to 0");
    check(rdData == 32'h3333_4444, "R6 high row literal", rdData, 32'h3333_4444);
    wr(32'h0000_2000, 32'h5555_6666, 4);
    rd(32'h0000_0800, 4, "R6 bank 1 aliases bank 0");
    rd(32'h0000_2000, 4, "R5 bank field above column");
    check(rdData == 32'h5555_6666, "R5 bank literal", rdData, 32'h5555_6666);
    rd(32'h0001_0000, 4, "R5 row field above bank");

    // R9: narrow accesses
    wr(32'h0000_0400, 32'h9999_0000, 2);
    rd(32'h0000_0400, 4, "R9 narrow write dropped");
    check(rdData == 32'h1111_2222, "R9 narrow literal", rdData, 32'h1111_2222);
    rd(32'h0000_0400, 2, "R9 narrow read");
    rd(32'h0000_0400, 1, "R9 byte read");

    // R4: unsupported size
    setSize(300);
    rd(32'h0000_0400, 4, "R4 unsupported reads zero");
    cfg(12'hAB4, "R4 unsupported cfg ignored");
    setSize(512);
    cfg(12'hAC4, "R4 512 matching closes");
    cfg(12'hAB4, "R4 512 row mismatch opens");
    rd(32'h0000_0400, 4, "R7 contents kept");
    setSize(1024);
    cfg(12'hAD4, "R4 1024 matching closes");
    cfg(12'hAE4, "R4 1024 row mismatch opens");

    // R7: random traffic over several geometries
    for (int round = 0; round < 6; round++) begin
      logic [11:0] c = 12'($urandom) & 12'hFF4;
      if (round == 2) setSize(256);
      if (round == 4) setSize(512);
      cfg(c, "R2 random geometry");
      if ((round % 2) == 1) cfg(12'($urandom) | 12'h001, "R3 random dual rank");
      for (int n = 0; n < 150; n++) begin
        int unsigned a = $urandom >> ($urandom % 32);
        int bytes = (($urandom % 8) == 0) ? 2 : 4;
        if ($urandom % 2) wr(a, $urandom, bytes);
        else rd(a, bytes, "R7 random read");
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule